// File: doc/BRIEF.md
# Submission Ring Producer with Tail Doorbell

This block is the host-side producer for one I/O submission ring that a storage controller reads from host memory. Software loads a ring description: queue number, ring base address, entry count and doorbell stride exponent. For every command slot it grants, the block gives the memory address where the 64-byte command must be placed, and it moves its tail index forward, returning to slot 0 after the last slot.

Granting a slot and telling the controller about it are separate actions. Any number of entries may be granted before a ring request. The ring request then produces a single register write to the queue's tail doorbell. That write carries the new tail index in its low dword and is padded to at least eight bytes. The doorbell address is built from the queue number and a power-of-two stride. The block keeps the most recent head index reported by the controller. It refuses new entries when one more entry would make the tail catch up with that head.

Top module: `sq_producer`

## Requirements
- R1: `slot_addr` equals the configured base plus 64 times the current tail index, so with base 0x1000_0000 and two entries granted it reads 0x1000_0080.
- R2: Each accepted entry (`cmd_valid` and `cmd_ready` both high at a clock edge) advances the tail by one. After slot size-1 the tail returns to slot 0.
- R3: The doorbell address is 0x1000 + (2*qid) * (4 << stride). Queue 0 with stride 0 gives 0x1000, queue 1 with stride 0 gives 0x1008, and queue 3 with stride 2 gives 0x1060.
- R4: A `ring_req` sampled while entries are unannounced produces exactly one `db_valid` pulse in the following cycle. The write data is the tail index after any entry accepted in that same cycle, and it covers every entry accepted since the previous doorbell write.
- R5: Every doorbell write is DB_BYTES (default 8) bytes wide, with all byte strobes set. The tail index sits in bits [15:0] and every other bit is zero.
- R6: A `ring_req` with no unannounced entries produces no doorbell write.
- R7: `cmd_ready` is low when advancing the tail would make it equal to the last reported head. A `cmd_valid` during that time leaves the tail and `slot_addr` unchanged.
- R8: A `head_valid` pulse stores `head_idx` as the controller head, and this clears the full condition when space opens.
- R9: `cfg_load` captures base, size, queue number and stride, clears tail, head and the announced index to 0, and activates the queue. Before the first load, `cmd_ready` is low.
- R10: After reset, `cmd_ready` and `db_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Configuration strobe |
| cfg_qid | input | QID_W | Queue number |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_size | input | IDX_W | Entries in the ring (at least 2) |
| cfg_stride | input | STRIDE_W | Doorbell stride exponent |
| cmd_valid | input | 1 | Request for a command slot |
| cmd_ready | output | 1 | Slot available |
| slot_addr | output | ADDR_W | Address for the granted 64-byte entry |
| head_valid | input | 1 | Controller head update strobe |
| head_idx | input | IDX_W | Controller head index |
| ring_req | input | 1 | Announce all pending entries |
| db_valid | output | 1 | Doorbell write pulse |
| db_addr | output | DB_ADDR_W | Doorbell register address |
| db_data | output | 8*DB_BYTES | Doorbell write data |
| db_strb | output | DB_BYTES | Doorbell byte strobes |

## Verification
`slot_addr` and `cmd_ready` are combinational from the registered tail, head and configuration. They are therefore due in the cycle right after the edge that accepted an entry, updated the head or loaded the configuration. The doorbell outputs pass through one output register, so `db_valid`, `db_addr` and `db_data` are due in the cycle after the edge that sampled `ring_req`, and `db_valid` drops one cycle later. The bench drives inputs on falling edges and reads results on the next falling edge. Each check therefore samples exactly the cycle after the capturing rising edge and never at an edge.

// File: rtl/sqp_pkg.sv
package sqp_pkg;
   localparam int unsigned ENTRY_LOG2     = 6;           // 64-byte entries
   localparam int unsigned DB_REGION_BASE = 32'h0000_1000;
   localparam int unsigned DB_MIN_BYTES   = 8;
   localparam int unsigned DB_WORD_SHIFT  = 2;           // 4 << stride
endpackage

// File: rtl/sqp_cfg_regs.sv
module sqp_cfg_regs #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned IDX_W     = 16,
   parameter int unsigned QID_W     = 16,
   parameter int unsigned STRIDE_W  = 4,
   parameter int unsigned DB_ADDR_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [QID_W-1:0]     qid,
   input  logic [ADDR_W-1:0]    base,
   input  logic [IDX_W-1:0]     size,
   input  logic [STRIDE_W-1:0]  stride,
   output logic                 active,
   output logic [ADDR_W-1:0]    base_q,
   output logic [IDX_W-1:0]     last_q,
   output logic [DB_ADDR_W-1:0] db_addr_q
);
   import sqp_pkg::*;

   logic [DB_ADDR_W-1:0] pair_off;
   logic [DB_ADDR_W-1:0] db_addr_d;

   always_comb begin
      pair_off  = DB_ADDR_W'({qid, 1'b0});
      db_addr_d = DB_ADDR_W'(DB_REGION_BASE) +
                  (pair_off << (DB_WORD_SHIFT + 32'(stride)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         base_q    <= '0;
         last_q    <= '0;
         db_addr_q <= '0;
      end else if (load) begin
         active    <= 1'b1;
         base_q    <= base;
         last_q    <= size - IDX_W'(1);
         db_addr_q <= db_addr_d;
      end
   end
endmodule

// File: rtl/sqp_ring_index.sv
module sqp_ring_index #(
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             active,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             cmd_valid,
   input  logic             head_valid,
   input  logic [IDX_W-1:0] head_idx,
   input  logic             ring_req,
   output logic             ready,
   output logic [IDX_W-1:0] tail,
   output logic [IDX_W-1:0] tail_next,
   output logic             ring_fire
);
   logic [IDX_W-1:0] tail_q, head_q, rung_q, tail_inc;
   logic             accept;

   always_comb begin
      tail_inc  = (tail_q == last_idx) ? '0 : tail_q + IDX_W'(1);
      ready     = active && (tail_inc != head_q);
      accept    = cmd_valid && ready;
      tail_next = accept ? tail_inc : tail_q;
      ring_fire = ring_req && active && !load && (tail_next != rung_q);
      tail      = tail_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         tail_q <= '0;
         head_q <= '0;
         rung_q <= '0;
      end else begin
         tail_q <= tail_next;
         if (head_valid) head_q <= head_idx;
         if (ring_fire)  rung_q <= tail_next;
      end
   end
endmodule

// File: rtl/sqp_slot_gen.sv
module sqp_slot_gen #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IDX_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  tail,
   output logic [ADDR_W-1:0] slot_addr
);
   import sqp_pkg::*;

   always_comb slot_addr = base + (ADDR_W'(tail) << ENTRY_LOG2);
endmodule

// File: rtl/sqp_db_issue.sv
module sqp_db_issue #(
   parameter int unsigned IDX_W     = 16,
   parameter int unsigned DB_ADDR_W = 32,
   parameter int unsigned DB_BYTES  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  logic [IDX_W-1:0]      value,
   input  logic [DB_ADDR_W-1:0]  addr,
   output logic                  db_valid,
   output logic [DB_ADDR_W-1:0]  db_addr,
   output logic [8*DB_BYTES-1:0] db_data,
   output logic [DB_BYTES-1:0]   db_strb
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         db_valid <= 1'b0;
         db_addr  <= '0;
         db_data  <= '0;
      end else begin
         db_valid <= fire;
         if (fire) begin
            db_addr <= addr;
            db_data <= (8*DB_BYTES)'(value);
         end
      end
   end

   always_comb db_strb = {DB_BYTES{1'b1}};
endmodule

// File: rtl/sq_producer.sv
module sq_producer #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned IDX_W     = 16,
   parameter int unsigned QID_W     = 16,
   parameter int unsigned STRIDE_W  = 4,
   parameter int unsigned DB_ADDR_W = 32,
   parameter int unsigned DB_BYTES  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic [QID_W-1:0]      cfg_qid,
   input  logic [ADDR_W-1:0]     cfg_base,
   input  logic [IDX_W-1:0]      cfg_size,
   input  logic [STRIDE_W-1:0]   cfg_stride,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   output logic [ADDR_W-1:0]     slot_addr,
   input  logic                  head_valid,
   input  logic [IDX_W-1:0]      head_idx,
   input  logic                  ring_req,
   output logic                  db_valid,
   output logic [DB_ADDR_W-1:0]  db_addr,
   output logic [8*DB_BYTES-1:0] db_data,
   output logic [DB_BYTES-1:0]   db_strb
);
   import sqp_pkg::*;

   localparam int unsigned DB_DATA_W = 8 * DB_BYTES;

   generate
      if (DB_BYTES < DB_MIN_BYTES) begin : g_bad_db
         $error("DB_BYTES must be at least 8");
      end
      if (IDX_W > DB_DATA_W) begin : g_bad_idx
         $error("IDX_W must fit in doorbell data");
      end
      if (ADDR_W < IDX_W + ENTRY_LOG2) begin : g_bad_addr
         $error("ADDR_W too small for ring");
      end
   endgenerate

   logic                 cfg_active;
   logic [ADDR_W-1:0]    base_q;
   logic [IDX_W-1:0]     last_q;
   logic [DB_ADDR_W-1:0] db_addr_cfg;
   logic [IDX_W-1:0]     tail, tail_next;
   logic                 ring_fire;

   sqp_cfg_regs #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .QID_W(QID_W),
      .STRIDE_W(STRIDE_W), .DB_ADDR_W(DB_ADDR_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .qid(cfg_qid),
      .base(cfg_base), .size(cfg_size), .stride(cfg_stride),
      .active(cfg_active), .base_q(base_q), .last_q(last_q),
      .db_addr_q(db_addr_cfg)
   );

   sqp_ring_index #(.IDX_W(IDX_W)) idx_i (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .active(cfg_active),
      .last_idx(last_q), .cmd_valid(cmd_valid), .head_valid(head_valid),
      .head_idx(head_idx), .ring_req(ring_req), .ready(cmd_ready),
      .tail(tail), .tail_next(tail_next), .ring_fire(ring_fire)
   );

   sqp_slot_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) slot_i (
      .base(base_q), .tail(tail), .slot_addr(slot_addr)
   );

   sqp_db_issue #(
      .IDX_W(IDX_W), .DB_ADDR_W(DB_ADDR_W), .DB_BYTES(DB_BYTES)
   ) db_i (
      .clk(clk), .rst_n(rst_n), .fire(ring_fire), .value(tail_next),
      .addr(db_addr_cfg), .db_valid(db_valid), .db_addr(db_addr),
      .db_data(db_data), .db_strb(db_strb)
   );
endmodule

// File: rtl/sqp_checker.sv
module sqp_checker #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned DB_BYTES = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_load,
   input logic                  cfg_active,
   input logic [ADDR_W-1:0]     base_q,
   input logic                  cmd_valid,
   input logic                  cmd_ready,
   input logic [ADDR_W-1:0]     slot_addr,
   input logic                  ring_req,
   input logic                  db_valid,
   input logic [8*DB_BYTES-1:0] db_data
);
   a_r2_slot_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !cfg_load) |=> (slot_addr != $past(slot_addr)));

   a_r7_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && !cfg_load) |=> $stable(slot_addr));

   a_r4_db_after_ring: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> $past(ring_req));

   a_r5_db_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> (db_data[8*DB_BYTES-1:16] == '0));

   a_r9_base_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && cfg_active) |=> $stable(base_q));

   a_r9_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_active |-> !cmd_ready);
endmodule

bind sq_producer sqp_checker #(.ADDR_W(ADDR_W), .DB_BYTES(DB_BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_active(cfg_active),
   .base_q(base_q), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .slot_addr(slot_addr), .ring_req(ring_req), .db_valid(db_valid),
   .db_data(db_data)
);

// File: tb/sq_producer_tb_top.sv
module sq_producer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [15:0] cfg_qid = '0;
   logic [63:0] cfg_base = '0;
   logic [15:0] cfg_size = '0;
   logic [3:0]  cfg_stride = '0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] slot_addr;
   logic        head_valid = 1'b0;
   logic [15:0] head_idx = '0;
   logic        ring_req = 1'b0;
   logic        db_valid;
   logic [31:0] db_addr;
   logic [63:0] db_data;
   logic [7:0]  db_strb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sq_producer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_qid(cfg_qid),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_stride(cfg_stride),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .slot_addr(slot_addr),
      .head_valid(head_valid), .head_idx(head_idx), .ring_req(ring_req),
      .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data),
      .db_strb(db_strb)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic configure(input logic [15:0] q, input logic [63:0] b,
                            input logic [15:0] s, input logic [3:0] st);
      @(negedge clk);
      cfg_load = 1'b1; cfg_qid = q; cfg_base = b; cfg_size = s; cfg_stride = st;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic push(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Ring; on return we are at the negedge where db_valid is due.
   task automatic ring();
      @(negedge clk);
      ring_req = 1'b1;
      @(negedge clk);
      ring_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 ready after reset", 64'(cmd_ready), 64'd0);
      chk("R10 db_valid after reset", 64'(db_valid), 64'd0);
      @(negedge clk); cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R9 not ready before load", 64'(cmd_ready), 64'd0);
   endtask

   task automatic t_basic();
      configure(16'd1, 64'h1000_0000, 16'd16, 4'd0);
      chk("R9 ready after load", 64'(cmd_ready), 64'd1);
      chk("R1 slot 0 addr", slot_addr, 64'h1000_0000);
      push(2);
      chk("R1 slot 2 addr", slot_addr, 64'h1000_0080);
      ring();
      chk("R4 db pulse", 64'(db_valid), 64'd1);
      chk("R3 db addr q1", 64'(db_addr), 64'h1008);
      chk("R4 db data tail 2", db_data, 64'd2);
      chk("R5 db strobes", 64'(db_strb), 64'hFF);
      @(negedge clk);
      chk("R4 db single pulse", 64'(db_valid), 64'd0);
      ring();
      chk("R6 no write when nothing pending", 64'(db_valid), 64'd0);
   endtask

   task automatic t_batch();
      push(3);
      chk("R1 slot 5 addr", slot_addr, 64'h1000_0140);
      chk("R6 no write before ring", 64'(db_valid), 64'd0);
      // ring in the same cycle as one more accept
      @(negedge clk);
      cmd_valid = 1'b1; ring_req = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; ring_req = 1'b0;
      chk("R4 batch db pulse", 64'(db_valid), 64'd1);
      chk("R4 batch db data includes same-cycle entry", db_data, 64'd6);
   endtask

   task automatic t_addr_variants();
      configure(16'd0, 64'h2000_0000, 16'd8, 4'd0);
      chk("R9 tail cleared on load", slot_addr, 64'h2000_0000);
      push(1);
      ring();
      chk("R3 admin db addr", 64'(db_addr), 64'h1000);
      configure(16'd3, 64'h3000_0000, 16'd8, 4'd2);
      push(1);
      ring();
      chk("R3 strided db addr", 64'(db_addr), 64'h1060);
      chk("R5 db data q3", db_data, 64'd1);
   endtask

   task automatic t_wrap_full();
      configure(16'd2, 64'h4000_0000, 16'd4, 4'd0);
      push(3);
      chk("R7 full after size-1 entries", 64'(cmd_ready), 64'd0);
      chk("R1 slot 3 addr", slot_addr, 64'h4000_00C0);
      @(negedge clk); cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R7 refused entry keeps slot", slot_addr, 64'h4000_00C0);
      ring();
      chk("R4 db data 3", db_data, 64'd3);
      @(negedge clk); head_valid = 1'b1; head_idx = 16'd2;
      @(negedge clk); head_valid = 1'b0;
      chk("R8 ready after head update", 64'(cmd_ready), 64'd1);
      push(1);
      chk("R2 tail wraps to slot 0", slot_addr, 64'h4000_0000);
      ring();
      chk("R2 db data after wrap", db_data, 64'd0);
      chk("R8 ready with one gap", 64'(cmd_ready), 64'd1);
      push(1);
      chk("R7 full again at head-1", 64'(cmd_ready), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_batch();
      t_addr_variants();
      t_wrap_full();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule